// File: doc/BRIEF.md
# Synthesizer Register Programming Sequencer

This block lives in an FPGA and brings up an external frequency synthesizer over a three-wire serial link made of a serial clock, a data line and a latch-enable strobe. A single-cycle start pulse makes it send a fixed list of thirteen 24-bit configuration words, in a fixed order. After the word that powers up the synthesizer's internal regulators, it pauses for a settling interval before the two writes that trigger VCO calibration.

The latch-enable line is driven high only to latch a finished word. While that line is high, the synthesizer's lock-detect pin carries test readback, so lock samples are used only once programming has finished and latch enable is low. The block reports busy while programming and done afterwards. Lock is reported only after a synchronized lock-detect level has stayed high without a break for a programmable number of clock cycles.

The serial half-bit time, the settling interval and the lock qualification length are parameters counted in system clock cycles. The default settling interval of 120000 cycles is 10 ms at a 12 MHz clock.

Top module: `synth_prog_seq`

## Requirements
- R1: One run sends 13 words, and the words latched are, in order, 0x840005, 0x800005, 0x8407F5 (three writes to register 5), then 0x01048C, 0x000BA9, 0x028018, 0x050307, 0x486656, 0x000004, 0x7CA623, 0x568022 (register 2), 0x204001 (register 1) and 0x2C0000 (register 0).
- R2: Each word is 24 bits, shifted most significant bit first. Data changes only while the serial clock is low, so it is stable at every serial clock rising edge. Each half of a bit lasts HALF_CYCLES clocks.
- R3: After the 24th bit, latch enable is high for one bit period (2*HALF_CYCLES clocks) while clock and data are low. At every other time latch enable is low, including before the first word and after the run.
- R4: After each latch pulse, clock and data stay low for at least one bit period before the next word begins.
- R5: Between the fall of latch enable for the register 2 word and the first serial clock rising edge of the register 1 word, at least WAIT_CYCLES clocks pass. No other pair of words has this pause.
- R6: busy_o rises in the cycle after an accepted start and stays high until the register 0 word's frame has ended. done_o then rises. A start pulse while busy_o is high has no effect on the bus or the status.
- R7: A start pulse while done_o is high clears done_o and begins a complete new run.
- R8: The lock-detect input passes through a two-flop synchronizer. locked_o rises once the synchronized level has been high for LOCK_CYCLES consecutive clocks with done_o high and latch enable low. Any low sample clears locked_o and restarts the count.
- R9: Lock-detect activity before done_o rises, including while latch enable is high, never sets locked_o.
- R10: While reset is held (synchronous, active high), all bus outputs, busy_o, done_o and locked_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Single-cycle request to run the programming list |
| ld_pin | input | 1 | Asynchronous lock-detect pin from the synthesizer |
| sclk_o | output | 1 | Serial clock to the synthesizer |
| sdata_o | output | 1 | Serial data to the synthesizer |
| le_o | output | 1 | Latch-enable strobe to the synthesizer |
| busy_o | output | 1 | Programming in progress |
| done_o | output | 1 | All words sent |
| locked_o | output | 1 | Qualified lock status |

## Verification
The hardest situation to reach is a lock-detect level that is high while latch enable is pulsing during programming, followed by the transition into done. The locked flag must start counting only from the first qualified cycle. The stimulus holds the lock pin high through the whole run and pulses start both during shifting and during the settling pause. After done, it drops the pin for a single cycle to force a recount, then restarts the run from the done state. A behavioural cycle model in the bench predicts every pin and status bit throughout. A bus decoder rebuilds the latched words and measures the low gaps and the settling pause.

// File: rtl/synth_seq_pkg.sv
package synth_seq_pkg;

    localparam int WORD_W     = 24;
    localparam int NUM_WORDS  = 13;
    localparam int IDX_W      = $clog2(NUM_WORDS);
    // index of the regulator power-up word; the pause follows its frame
    localparam int PAUSE_IDX  = 10;
    // phases of one frame, each lasting one half-bit time
    localparam int PH_DATA    = 2 * WORD_W;
    localparam int PH_LATCH   = 2;
    localparam int PH_GAP     = 2;
    localparam int PH_TOTAL   = PH_DATA + PH_LATCH + PH_GAP;
    localparam int PH_W       = $clog2(PH_TOTAL);

    typedef logic [WORD_W-1:0] cfg_word_t;
    typedef logic [IDX_W-1:0]  word_idx_t;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_SEND,
        SQ_PAUSE,
        SQ_FINISHED
    } seq_state_t;

    typedef struct packed {
        logic sclk;
        logic sdata;
        logic le;
    } ser_pins_t;

    function automatic cfg_word_t cfg_word(input word_idx_t i);
        cfg_word_t w;
        case (i)
            4'd0:    w = 24'h840005;
            4'd1:    w = 24'h800005;
            4'd2:    w = 24'h8407F5;
            4'd3:    w = 24'h01048C;
            4'd4:    w = 24'h000BA9;
            4'd5:    w = 24'h028018;
            4'd6:    w = 24'h050307;
            4'd7:    w = 24'h486656;
            4'd8:    w = 24'h000004;
            4'd9:    w = 24'h7CA623;
            4'd10:   w = 24'h568022;
            4'd11:   w = 24'h204001;
            4'd12:   w = 24'h2C0000;
            default: w = '0;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/synth_ser_shift.sv
module synth_ser_shift
    import synth_seq_pkg::*;
#(
    parameter int HALF_CYCLES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      load,
    input  cfg_word_t word_in,
    output logic      frame_end,
    output ser_pins_t pins
);
    localparam int DIV_W = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;
    localparam int BS_W  = $clog2(WORD_W);

    logic             active;
    logic [PH_W-1:0]  ph;
    logic [DIV_W-1:0] div;
    cfg_word_t        word_q;
    logic             half_end;
    logic [BS_W-1:0]  bit_sel;

    assign half_end  = (div == DIV_W'(HALF_CYCLES - 1));
    assign frame_end = active && half_end && (ph == PH_W'(PH_TOTAL - 1));
    assign bit_sel   = BS_W'(WORD_W - 1 - int'(ph >> 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            ph     <= '0;
            div    <= '0;
            word_q <= '0;
        end else if (load) begin
            active <= 1'b1;
            ph     <= '0;
            div    <= '0;
            word_q <= word_in;
        end else if (active) begin
            if (half_end) begin
                div <= '0;
                if (ph == PH_W'(PH_TOTAL - 1)) begin
                    active <= 1'b0;
                end else begin
                    ph <= ph + 1'b1;
                end
            end else begin
                div <= div + 1'b1;
            end
        end
    end

    always_comb begin
        pins = '0;
        if (active) begin
            if (ph < PH_W'(PH_DATA)) begin
                pins.sclk  = ph[0];
                pins.sdata = word_q[bit_sel];
            end else if (ph < PH_W'(PH_DATA + PH_LATCH)) begin
                pins.le = 1'b1;
            end
        end
    end

    AST_LATCH_QUIET: assert property (@(posedge clk) disable iff (rst)
        pins.le |-> (!pins.sclk && !pins.sdata)); // R3

endmodule

// File: rtl/synth_wait_timer.sv
module synth_wait_timer #(
    parameter int WAIT_CYCLES = 120000
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    output logic expired
);
    localparam int CW = $clog2(WAIT_CYCLES + 1);

    logic          running;
    logic [CW-1:0] cnt;

    assign expired = running && (cnt == CW'(WAIT_CYCLES - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
            cnt     <= '0;
        end else if (arm) begin
            running <= 1'b1;
            cnt     <= '0;
        end else if (running) begin
            if (expired) begin
                running <= 1'b0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/synth_lock_qual.sv
module synth_lock_qual #(
    parameter int LOCK_CYCLES = 256
) (
    input  logic clk,
    input  logic rst,
    input  logic ld_pin,
    input  logic enable,
    output logic locked
);
    localparam int CW = (LOCK_CYCLES > 1) ? $clog2(LOCK_CYCLES) : 1;

    logic          sync1;
    logic          sync2;
    logic [CW-1:0] cnt;
    logic          qual;

    assign qual = enable && sync2;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1  <= 1'b0;
            sync2  <= 1'b0;
            cnt    <= '0;
            locked <= 1'b0;
        end else begin
            sync1 <= ld_pin;
            sync2 <= sync1;
            if (!qual) begin
                cnt    <= '0;
                locked <= 1'b0;
            end else if (cnt == CW'(LOCK_CYCLES - 1)) begin
                locked <= 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    AST_LOCK_DROPS: assert property (@(posedge clk) disable iff (rst)
        (locked && !sync2) |=> !locked); // R8

endmodule

// File: rtl/synth_prog_seq.sv
module synth_prog_seq
    import synth_seq_pkg::*;
#(
    parameter int HALF_CYCLES = 2,
    parameter int WAIT_CYCLES = 120000,
    parameter int LOCK_CYCLES = 256
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic ld_pin,
    output logic sclk_o,
    output logic sdata_o,
    output logic le_o,
    output logic busy_o,
    output logic done_o,
    output logic locked_o
);
    localparam int GAP_W = $clog2(WAIT_CYCLES + 1);

    seq_state_t state, state_nx;
    word_idx_t  idx, load_idx;
    logic       load;
    logic       arm;
    logic       expired;
    logic       frame_end;
    ser_pins_t  pins, pins_q;

    always_comb begin
        state_nx = state;
        load     = 1'b0;
        load_idx = idx;
        arm      = 1'b0;
        case (state)
            SQ_IDLE, SQ_FINISHED: begin
                if (start) begin
                    load     = 1'b1;
                    load_idx = '0;
                    state_nx = SQ_SEND;
                end
            end
            SQ_SEND: begin
                if (frame_end) begin
                    if (idx == IDX_W'(NUM_WORDS - 1)) begin
                        state_nx = SQ_FINISHED;
                    end else if (idx == IDX_W'(PAUSE_IDX)) begin
                        arm      = 1'b1;
                        state_nx = SQ_PAUSE;
                    end else begin
                        load     = 1'b1;
                        load_idx = idx + 1'b1;
                    end
                end
            end
            SQ_PAUSE: begin
                if (expired) begin
                    load     = 1'b1;
                    load_idx = idx + 1'b1;
                    state_nx = SQ_SEND;
                end
            end
            default: state_nx = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SQ_IDLE;
            idx    <= '0;
            pins_q <= '0;
        end else begin
            state  <= state_nx;
            pins_q <= pins;
            if (load) begin
                idx <= load_idx;
            end
        end
    end

    synth_ser_shift #(.HALF_CYCLES(HALF_CYCLES)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .word_in   (cfg_word(load_idx)),
        .frame_end (frame_end),
        .pins      (pins)
    );

    synth_wait_timer #(.WAIT_CYCLES(WAIT_CYCLES)) u_wait (
        .clk     (clk),
        .rst     (rst),
        .arm     (arm),
        .expired (expired)
    );

    synth_lock_qual #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
        .clk    (clk),
        .rst    (rst),
        .ld_pin (ld_pin),
        .enable (done_o && !le_o),
        .locked (locked_o)
    );

    assign sclk_o  = pins_q.sclk;
    assign sdata_o = pins_q.sdata;
    assign le_o    = pins_q.le;
    assign busy_o  = (state == SQ_SEND) || (state == SQ_PAUSE);
    assign done_o  = (state == SQ_FINISHED);

    // cycles since latch enable last fell, saturating; watches the pause
    logic [GAP_W-1:0] gap_cnt;
    always_ff @(posedge clk) begin
        if (rst || le_o) begin
            gap_cnt <= '0;
        end else if (gap_cnt < GAP_W'(WAIT_CYCLES)) begin
            gap_cnt <= gap_cnt + 1'b1;
        end
    end

    AST_PAUSE_KEPT: assert property (@(posedge clk) disable iff (rst)
        ($rose(sclk_o) && idx == IDX_W'(PAUSE_IDX + 1) && gap_cnt != '0 && $past(state) == SQ_SEND)
        |-> gap_cnt >= GAP_W'(WAIT_CYCLES)); // R5

    AST_DATA_HELD: assert property (@(posedge clk) disable iff (rst)
        !$stable(sdata_o) |-> !sclk_o); // R2

    AST_LE_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !$past(busy_o)) |-> !le_o); // R3

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_SEND && start && !frame_end) |=> (idx == $past(idx) && busy_o)); // R6

    AST_LOCK_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
        $rose(locked_o) |-> (done_o && !le_o)); // R9

endmodule

// File: tb/synth_prog_seq_bench.sv
module synth_prog_seq_bench;

    localparam int HALF  = 2;
    localparam int WAITC = 60;
    localparam int LOCKC = 256;
    localparam int FRAME = 52 * HALF;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic ld_pin = 1'b0;
    logic sclk_o, sdata_o, le_o, busy_o, done_o, locked_o;

    always #10 clk = ~clk;

    synth_prog_seq #(
        .HALF_CYCLES (HALF),
        .WAIT_CYCLES (WAITC),
        .LOCK_CYCLES (LOCKC)
    ) u_synth_prog_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .ld_pin   (ld_pin),
        .sclk_o   (sclk_o),
        .sdata_o  (sdata_o),
        .le_o     (le_o),
        .busy_o   (busy_o),
        .done_o   (done_o),
        .locked_o (locked_o)
    );

    logic [23:0] exp_words [13];
    initial begin
        exp_words[0]  = 24'h840005; exp_words[1]  = 24'h800005;
        exp_words[2]  = 24'h8407F5; exp_words[3]  = 24'h01048C;
        exp_words[4]  = 24'h000BA9; exp_words[5]  = 24'h028018;
        exp_words[6]  = 24'h050307; exp_words[7]  = 24'h486656;
        exp_words[8]  = 24'h000004; exp_words[9]  = 24'h7CA623;
        exp_words[10] = 24'h568022; exp_words[11] = 24'h204001;
        exp_words[12] = 24'h2C0000;
    end

    int total = 0;
    int bad   = 0;

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int   m_mode = 0;   // 0 idle, 1 sending, 2 pause, 3 finished
    int   m_widx = 0;
    int   m_cyc  = 0;
    logic e_sclk = 0, e_sdata = 0, e_le = 0;
    logic m_s1 = 0, m_s2 = 0, e_lock = 0;
    int   m_lcnt = 0;
    logic model_live = 0;

    always @(posedge clk) begin
        model_live <= 1'b1;
        if (rst) begin
            m_mode = 0; m_widx = 0; m_cyc = 0;
            e_sclk = 0; e_sdata = 0; e_le = 0;
            m_s1 = 0; m_s2 = 0; e_lock = 0; m_lcnt = 0;
        end else begin
            // lock qualification from values before this edge
            if (m_mode == 3 && !e_le && m_s2) begin
                if (m_lcnt >= LOCKC - 1) e_lock = 1;
                else m_lcnt++;
            end else begin
                m_lcnt = 0; e_lock = 0;
            end
            m_s2 = m_s1;
            m_s1 = ld_pin;
            // pins registered from the model's current position
            e_sclk = 0; e_sdata = 0; e_le = 0;
            if (m_mode == 1) begin
                int ph;
                ph = m_cyc / HALF;
                if (ph < 48) begin
                    e_sclk  = ph[0];
                    e_sdata = exp_words[m_widx][23 - ph / 2];
                end else if (ph < 50) begin
                    e_le = 1;
                end
            end
            case (m_mode)
                0, 3: if (start) begin m_mode = 1; m_widx = 0; m_cyc = 0; end
                1: begin
                    if (m_cyc == FRAME - 1) begin
                        m_cyc = 0;
                        if (m_widx == 12) m_mode = 3;
                        else if (m_widx == 10) m_mode = 2;
                        else m_widx++;
                    end else m_cyc++;
                end
                default: begin
                    if (m_cyc == WAITC - 1) begin
                        m_mode = 1; m_widx = 11; m_cyc = 0;
                    end else m_cyc++;
                end
            endcase
        end
    end

    always @(negedge clk) begin
        if (model_live) begin
            check(sclk_o == e_sclk,   "R2 sclk",  sclk_o,  e_sclk);
            check(sdata_o == e_sdata, "R2 sdata", sdata_o, e_sdata);
            check(le_o == e_le,       "R3 le",    le_o,    e_le);
            check(busy_o == (m_mode == 1 || m_mode == 2), "R6 busy", busy_o, (m_mode == 1 || m_mode == 2));
            check(done_o == (m_mode == 3), "R6 done", done_o, (m_mode == 3));
            check(locked_o == e_lock, "R8 locked", locked_o, e_lock);
        end
    end

    // ---------------- bus decoder ----------------
    logic        p_sclk = 0, p_sdata = 0, p_le = 0;
    logic [23:0] sh = '0;
    int nbits = 0, nwords = 0, lowrun = 0;
    int min_gap = 1 << 30, pause_gap = 0;
    int r2_viol = 0, r3_viol = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (sclk_o && sdata_o != p_sdata) r2_viol++;
            if (le_o && (sclk_o || sdata_o)) r3_viol++;
            if (sclk_o && !p_sclk) begin
                if (nbits == 0 && nwords > 0) begin
                    if ((nwords % 13) == 11) pause_gap = lowrun;
                    else if (lowrun < min_gap) min_gap = lowrun;
                end
                sh = {sh[22:0], sdata_o};
                nbits++;
            end
            if (le_o && !p_le) begin
                check(nbits == 24, "R2 bits per word", nbits, 24);
                check(sh == exp_words[nwords % 13], "R1 word", sh, exp_words[nwords % 13]);
                nwords++;
                nbits = 0;
            end
            if (!le_o && p_le) lowrun = 0;
            else if (!le_o && !sclk_o) lowrun++;
        end
        p_sclk = sclk_o; p_sdata = sdata_o; p_le = le_o;
    end

    // ---------------- watchdog ----------------
    int cyc_count = 0;
    always @(posedge clk) begin
        cyc_count++;
        if (cyc_count > 20000) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=%0d expected<20000", cyc_count);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 5000 && !done_o; i++) @(negedge clk);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        // R10: outputs while reset is held
        check(!sclk_o && !sdata_o && !le_o, "R10 bus in reset", {sclk_o, sdata_o, le_o}, 0);
        check(!busy_o && !done_o && !locked_o, "R10 status in reset", {busy_o, done_o, locked_o}, 0);
        @(negedge clk); rst = 1'b0;
        repeat (10) @(negedge clk);
        check(!le_o, "R3 le low before first word", le_o, 0);
        // R9: lock pin high all through programming (readback window)
        ld_pin = 1'b1;
        pulse_start();
        check(busy_o, "R6 busy after start", busy_o, 1);
        repeat (300) @(negedge clk);
        pulse_start();                       // R6: ignored mid-word
        for (int i = 0; i < 3000 && !(busy_o && !sclk_o && !le_o && nwords == 11 && lowrun > 10); i++)
            @(negedge clk);
        pulse_start();                       // R6: ignored during the pause
        check(!locked_o, "R9 no lock while busy", locked_o, 0);
        wait_done();
        check(done_o && !busy_o, "R6 done after run", {done_o, busy_o}, 2);
        check(nwords == 13, "R1 word count", nwords, 13);
        check(!locked_o, "R9 not locked at done", locked_o, 0);
        check(pause_gap >= WAITC, "R5 pause before register 1 word", pause_gap, WAITC);
        check(min_gap >= 2 * HALF && min_gap < WAITC, "R4 gap between words", min_gap, 2 * HALF);
        check(r2_viol == 0, "R2 data change with clock high", r2_viol, 0);
        check(r3_viol == 0, "R3 clock or data during latch", r3_viol, 0);
        repeat (100) @(negedge clk);
        check(!locked_o, "R8 lock not yet qualified", locked_o, 0);
        repeat (200) @(negedge clk);
        check(locked_o, "R8 locked after qualification", locked_o, 1);
        ld_pin = 1'b0; @(negedge clk); ld_pin = 1'b1;
        repeat (4) @(negedge clk);
        check(!locked_o, "R8 dropout clears lock", locked_o, 0);
        repeat (300) @(negedge clk);
        check(locked_o, "R8 relocked", locked_o, 1);
        // R7: restart from finished
        pulse_start();
        check(busy_o && !done_o, "R7 restart", {busy_o, done_o}, 2);
        repeat (3) @(negedge clk);
        check(!locked_o, "R9 lock cleared on restart", locked_o, 0);
        wait_done();
        check(nwords == 26, "R7 second run word count", nwords, 26);
        check(done_o, "R7 second run done", done_o, 1);
        repeat (5) @(negedge clk);
        check(!le_o, "R3 le low after run", le_o, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule